// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block pairs one bus master with one register-file slave. They exchange single words over a bus that has no shared clock. The pace of each transfer is set by a return-to-zero request/acknowledge sequence. Inside, both agents are ordinary clocked logic. Each agent passes the strobe it receives from the other side through a two-flop synchronizer before acting on it. A user starts a transfer on the master's command port by giving an address, a direction and, for writes, a data word. The master places these on the bus and keeps them still for a settle interval, so the slave can decode whether it is the target. Only then does the master raise the request.

The slave checks the upper address bits against its window. On a write it stores the word and raises acknowledge. On a read it puts the stored word on the data lines together with acknowledge. The master releases the request when it sees acknowledge, and it takes the read word at that moment. The slave releases acknowledge once it sees the request go low. The master pulses done when it sees acknowledge low again. Only after that does it accept the next command.

Top module: `hs_bus_top`

## Requirements
- R1: After reset, busReq, busAck, slvDrive and cmdDone are low, and cmdRData is zero. All slave registers hold zero.
- R2: A cmdStart sampled while the master is idle loads the command onto the bus at that edge. busReq rises exactly SETTLE clock cycles later (default 2). busAddr equals the command address throughout that interval.
- R3: On a write (cmdWrite = 1) the slave stores cmdWData in register cmdAddr[IDX_W-1:0]. The address must fall in the slave window, meaning cmdAddr[ADDR_W-1:IDX_W] equals SLV_BASE. busAck rises 3 cycles after busReq rises. A later read of that address returns the stored word.
- R4: On a read (cmdWrite = 0) the slave drives the stored word with slvDrive high for exactly the cycles in which busAck is high. slvDrive never goes high on a write.
- R5: The master drops busReq 3 cycles after busAck rises. On a read, cmdRData then holds the word the slave drove.
- R6: The slave drops busAck 3 cycles after busReq falls.
- R7: cmdDone is high for exactly one cycle, 3 cycles after busAck falls, which is SETTLE+12 cycles after the start edge. cmdRData holds its value until the next read completes.
- R8: A cmdStart during a transfer is ignored. The bus address stays unchanged, only one done pulse is produced, and no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both agents |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Begin a transfer (sampled when idle) |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W | Target address |
| cmdWData | input | DATA_W | Word to write |
| cmdDone | output | 1 | One-cycle completion pulse |
| cmdRData | output | DATA_W | Last word read |
| busReq | output | 1 | Request line as driven by the master |
| busAck | output | 1 | Acknowledge line as driven by the slave |
| busAddr | output | ADDR_W | Address lines held by the master |
| slvDrive | output | 1 | Slave is driving the data lines |

## Verification
Each transfer is timed from its start edge, with k counting completed edges after it. The expected values are:
- busReq is high for k = SETTLE to SETTLE+5.
- busAck is high for k = SETTLE+3 to SETTLE+8.
- slvDrive on a read matches busAck.
- cmdDone is high only at k = SETTLE+12.

The bench works these windows out from the synchronizer and register counts. It drives inputs on the falling edge and compares every output on every falling edge against them. Read data is checked against a model array in the done cycle. An extra start pulse injected mid-transfer must leave every window and the stored contents unchanged.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_REQ, M_REL} mState_t;
  typedef enum logic {S_IDLE, S_ACK} sState_t;
  // strobes from master control to master datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic finish;
  } mStrobe_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
    end
  endgenerate
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hs_master_ctrl.sv
module hs_master_ctrl
  import hs_pkg::*;
#(
  parameter int SETTLE = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     ackIn,
  output logic     busReq,
  output logic     cmdDone,
  output mStrobe_t strobe
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  mState_t state;
  logic [CNT_W-1:0] settleCnt;
  logic ackSync;

  hs_sync #(.STAGES(SYNC_STAGES)) i_ackSync (
    .clk(clk), .rstN(rstN), .din(ackIn), .dout(ackSync)
  );

  always_comb begin
    strobe.load    = (state == M_IDLE) && cmdStart;
    strobe.capture = (state == M_REQ) && ackSync;
    strobe.finish  = (state == M_REL) && !ackSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= M_IDLE;
      settleCnt <= '0;
      cmdDone   <= 1'b0;
    end else begin
      cmdDone <= strobe.finish;
      case (state)
        M_IDLE:
          if (cmdStart) begin
            state     <= M_SETTLE;
            settleCnt <= '0;
          end
        M_SETTLE:
          if (settleCnt == CNT_W'(SETTLE - 1)) state <= M_REQ;
          else settleCnt <= settleCnt + 1'b1;
        M_REQ:   if (ackSync)  state <= M_REL;
        M_REL:   if (!ackSync) state <= M_IDLE;
        default: state <= M_IDLE;
      endcase
    end
  end

  assign busReq = (state == M_REQ);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);
  // R5
  req_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> ackSync);
endmodule

// File: rtl/hs_master_dp.sv
module hs_master_dp
  import hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mStrobe_t          strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdWrite,
  input  logic [DATA_W-1:0] cmdWData,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] mstData,
  output logic              mstDrive,
  output logic [DATA_W-1:0] cmdRData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      busWrite <= 1'b0;
      mstData  <= '0;
      mstDrive <= 1'b0;
      cmdRData <= '0;
    end else begin
      if (strobe.load) begin
        busAddr  <= cmdAddr;
        busWrite <= cmdWrite;
        mstData  <= cmdWData;
        mstDrive <= cmdWrite;
      end
      if (strobe.capture && !busWrite) cmdRData <= busDataIn;
      if (strobe.finish) mstDrive <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W = 4,
  parameter int SLV_BASE = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busAck,
  output logic [DATA_W-1:0] slvData,
  output logic              slvDrive
);
  localparam int SEL_W = ADDR_W - IDX_W;
  localparam int REGS  = 1 << IDX_W;

  sState_t state;
  logic reqSync;
  logic hit;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] regFile [REGS];

  hs_sync #(.STAGES(SYNC_STAGES)) i_reqSync (
    .clk(clk), .rstN(rstN), .din(reqIn), .dout(reqSync)
  );

  assign hit = (busAddr[ADDR_W-1:IDX_W] == SEL_W'(SLV_BASE));
  assign idx = busAddr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      busAck   <= 1'b0;
      slvDrive <= 1'b0;
      slvData  <= '0;
      for (int i = 0; i < REGS; i++) regFile[i] <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (reqSync && hit) begin
            busAck <= 1'b1;
            state  <= S_ACK;
            if (busWrite) regFile[idx] <= busDataIn;
            else begin
              slvData  <= regFile[idx];
              slvDrive <= 1'b1;
            end
          end
        S_ACK:
          if (!reqSync) begin
            busAck   <= 1'b0;
            slvDrive <= 1'b0;
            state    <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  drive_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    slvDrive |-> busAck && !busWrite);
  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAck) |-> !reqSync);
endmodule

// File: rtl/hs_bus_top.sv
module hs_bus_top
  import hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W = 4,
  parameter int SLV_BASE = 10,
  parameter int SETTLE = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWData,
  output logic              cmdDone,
  output logic [DATA_W-1:0] cmdRData,
  output logic              busReq,
  output logic              busAck,
  output logic [ADDR_W-1:0] busAddr,
  output logic              slvDrive
);
  mStrobe_t strobe;
  logic busWrite, mstDrive;
  logic [DATA_W-1:0] mstData, slvData, busData;

  hs_master_ctrl #(.SETTLE(SETTLE), .SYNC_STAGES(SYNC_STAGES)) i_mCtrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .ackIn(busAck),
    .busReq(busReq), .cmdDone(cmdDone), .strobe(strobe)
  );

  hs_master_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdWrite(cmdWrite), .cmdWData(cmdWData), .busDataIn(busData),
    .busAddr(busAddr), .busWrite(busWrite), .mstData(mstData),
    .mstDrive(mstDrive), .cmdRData(cmdRData)
  );

  hs_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
             .SLV_BASE(SLV_BASE), .SYNC_STAGES(SYNC_STAGES)) i_slave (
    .clk(clk), .rstN(rstN), .reqIn(busReq), .busAddr(busAddr),
    .busWrite(busWrite), .busDataIn(busData), .busAck(busAck),
    .slvData(slvData), .slvDrive(slvDrive)
  );

  // shared data lines: whichever agent enables its driver, else idle low
  assign busData = slvDrive ? slvData : (mstDrive ? mstData : '0);

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(slvDrive && mstDrive));
  // R3
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> busReq);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq || busAck) |-> $stable(busAddr));
endmodule

// File: tb/test_hs_bus_top.sv
module test_hs_bus_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int SETTLE = 2;
  localparam int LAST = SETTLE + 12;

  logic clk = 0, rstN = 0;
  logic cmdStart = 0, cmdWrite = 0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdWData = '0;
  logic cmdDone, busReq, busAck, slvDrive;
  logic [DATA_W-1:0] cmdRData;
  logic [ADDR_W-1:0] busAddr;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model [16];
  logic [DATA_W-1:0] lastRd = '0;

  always #10 clk = ~clk;

  hs_bus_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)) i_hs_bus_top (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWData(cmdWData), .cmdDone(cmdDone),
    .cmdRData(cmdRData), .busReq(busReq), .busAck(busAck),
    .busAddr(busAddr), .slvDrive(slvDrive)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  // one transfer; k = edges completed since the start edge
  task automatic txn(bit wr, logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] data,
                     bit poke);
    bit expReq, expAck, expDrv, expDone;
    cmdStart = 1; cmdWrite = wr; cmdAddr = addr; cmdWData = data;
    for (int k = 0; k <= LAST + 1; k++) begin
      @(negedge clk);
      cmdStart = 0;
      if (poke && k == 4) begin
        cmdStart = 1; cmdWrite = 1; cmdAddr = 8'hA7; cmdWData = 16'hDEAD;
      end
      if (poke && k == 5) begin
        cmdStart = 0; cmdWrite = wr; cmdAddr = addr; cmdWData = data;
      end
      expReq  = (k >= SETTLE) && (k <= SETTLE + 5);
      expAck  = (k >= SETTLE + 3) && (k <= SETTLE + 8);
      expDrv  = !wr && expAck;
      expDone = (k == LAST);
      chk("R2/R5 busReq", busReq, expReq, k);
      chk("R3/R6 busAck", busAck, expAck, k);
      chk("R4 slvDrive", slvDrive, expDrv, k);
      chk("R7/R8 cmdDone", cmdDone, expDone, k);
      if (k <= LAST) chk("R2/R8 busAddr", busAddr, addr, k);
      if (k == LAST) begin
        if (wr) model[addr[3:0]] = data;
        else lastRd = model[addr[3:0]];
        chk("R5/R7 cmdRData", cmdRData, lastRd, k);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busReq", busReq, 0, 0);
    chk("R1 busAck", busAck, 0, 0);
    chk("R1 slvDrive", slvDrive, 0, 0);
    chk("R1 cmdDone", cmdDone, 0, 0);
    chk("R1 cmdRData", cmdRData, 0, 0);
    rstN = 1;
    @(negedge clk);
    // R1 registers read zero
    txn(0, 8'hA3, '0, 0);
    // R3 writes, R4/R5 read back
    txn(1, 8'hA3, 16'h1234, 0);
    txn(1, 8'hAF, 16'hBEEF, 0);
    txn(1, 8'hA0, 16'hFFFF, 0);
    txn(0, 8'hA3, '0, 0);
    txn(0, 8'hAF, '0, 0);
    txn(0, 8'hA0, '0, 0);
    // R7 rdata held across a write
    txn(1, 8'hA5, 16'h0F0F, 0);
    // R8 stray start mid-read and mid-write
    txn(0, 8'hAF, '0, 1);
    txn(1, 8'hA1, 16'h5555, 1);
    txn(0, 8'hA7, '0, 0);   // R8 no write to A7: still zero
    txn(0, 8'hA1, '0, 0);
    txn(0, 8'hA5, '0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule